// File: doc/BRIEF.md
# Trap Entry State Updater

This block holds the trap-related control state of a processor hart and updates all of it in a single clock edge when the pipeline signals that a trap is being taken. It is given the trap cause, with the most significant bit flagging an interrupt, the program counter of the trapping instruction and an optional faulting address with its valid flag. From these and the delegation masks it decides whether the supervisor or the machine level handles the trap. It then loads the redirected program counter and the new privilege, records the trap in the handling level's saved-PC, cause and faulting-address registers, and pushes the interrupt-enable and privilege stack in the status fields.

The vector bases, the two delegation masks, the status fields and the current privilege are held inside the block and are loaded through a small configuration write port. The delegation masks and the machine vector register apply fixed write masks. A separate input marks that the hart is in debug mode. In that mode a trap only redirects the program counter to one of two fixed debug addresses and leaves all other state alone.

Top module: `trap_entry_unit`

## Requirements
- R1: After the asynchronous reset, priv_o is machine (3), pc_o equals RESET_PC, and every status bit, vector base, delegation mask and per-level saved register reads zero.
- R2: An interrupt (cause bit XLEN-1 set) looks up bit index cause[XLEN-2:0] in the interrupt delegation mask, and an exception looks up the same index in the exception delegation mask. The trap is handled at supervisor level (priv 1) only when the current privilege is user (0) or supervisor (1), the index is below XLEN and the looked-up bit is 1. Any other trap is handled at machine level (priv 3).
- R3: A trap taken while priv_o is machine is always handled at machine level, whatever the masks hold.
- R4: A supervisor-handled trap sets spie_o to the old sie_o, sets spp_o to bit 0 of the old privilege and clears sie_o. It loads sepc_o from epc_i and scause_o from cause_i, sets pc_o to stvec_o and sets priv_o to 1. The machine-level registers are left unchanged.
- R5: A machine-handled trap sets mpie_o to the old mie_o, sets mpp_o to the old privilege and clears mie_o. It loads mepc_o from epc_i and mcause_o from cause_i and sets priv_o to 3. The supervisor-level registers are left unchanged.
- R6: For a machine-handled trap, pc_o is mtvec_o with bit 0 cleared. When mtvec_o bit 0 is 1 and the trap is an interrupt, 4 times the cause index is added, modulo 2^XLEN. Exceptions are never offset.
- R7: A configuration write to the machine vector (select 0) stores the data with bit 1 cleared and bit 0 kept as the vectored-mode flag. A write to the supervisor vector (select 1) stores the data with bits 1:0 cleared.
- R8: The handling level's faulting-address register is loaded from badaddr_i only when badaddr_vld_i is 1. Otherwise it keeps its value.
- R9: While dbg_mode_i is 1, a trap with cause 3 (exception, breakpoint) sets pc_o to DBG_ENTRY_PC, and any other cause sets pc_o to DBG_EXC_PC. Privilege, status and all saved registers are left unchanged.
- R10: The exception delegation mask (select 2) stores only bits 0, 3, 8, 12, 13 and 15, and the interrupt delegation mask (select 3) stores only bits 1, 5 and 9. All other bits read zero.
- R11: All updates take effect on the rising edge at which take_i is 1 and are visible at the outputs in the following cycle. Without take_i or a configuration write, no output changes.
- R12: A status write (select 4) loads sie, mie, spie, mpie, spp and mpp from data bits 1, 3, 5, 7, 8 and 12:11. A privilege write (select 5) loads data bits 1:0, except that the reserved value 2 is ignored. A configuration write in the same cycle as take_i is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | Trap is taken this cycle |
| cause_i | input | XLEN | Trap cause, MSB set for interrupts |
| epc_i | input | XLEN | PC of the trapping instruction |
| badaddr_i | input | XLEN | Faulting address |
| badaddr_vld_i | input | 1 | badaddr_i carries a valid address |
| dbg_mode_i | input | 1 | Hart is in debug mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration target: 0 mvec, 1 svec, 2 edeleg, 3 ideleg, 4 status, 5 priv |
| cfg_wdata_i | input | XLEN | Configuration write data |
| pc_o | output | XLEN | Redirected program counter |
| priv_o | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| mtvec_o | output | XLEN | Machine vector base and mode flag |
| stvec_o | output | XLEN | Supervisor vector base |
| medeleg_o | output | XLEN | Exception delegation mask |
| mideleg_o | output | XLEN | Interrupt delegation mask |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous interrupt enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous interrupt enable |
| mpp_o | output | 2 | Machine previous privilege |
| sepc_o | output | XLEN | Supervisor saved PC |
| scause_o | output | XLEN | Supervisor cause |
| sbadaddr_o | output | XLEN | Supervisor faulting address |
| mepc_o | output | XLEN | Machine saved PC |
| mcause_o | output | XLEN | Machine cause |
| mbadaddr_o | output | XLEN | Machine faulting address |

## Verification
Every piece of state is a port, so a wrong privilege, enable bit or saved register shows up in the first cycle after the edge that corrupted it. A misrouted trap has a second effect: the wrong level's saved registers change and the other level's stay stale, and the next nested trap then pushes a wrong previous privilege. The delegation and vectoring paths are exercised from user, supervisor and machine level, with interrupt indices inside and beyond XLEN and with the vector mode flag on and off, because the only symptom of an error there may be a program counter off by a multiple of four.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_RSV = 2'd2;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [2:0] SEL_MVEC   = 3'd0;
  localparam logic [2:0] SEL_SVEC   = 3'd1;
  localparam logic [2:0] SEL_EDELEG = 3'd2;
  localparam logic [2:0] SEL_IDELEG = 3'd3;
  localparam logic [2:0] SEL_STATUS = 3'd4;
  localparam logic [2:0] SEL_PRIV   = 3'd5;

  // status field positions inside a configuration write word
  localparam int unsigned POS_SIE  = 1;
  localparam int unsigned POS_MIE  = 3;
  localparam int unsigned POS_SPIE = 5;
  localparam int unsigned POS_MPIE = 7;
  localparam int unsigned POS_SPP  = 8;
  localparam int unsigned POS_MPP  = 11;

  localparam int unsigned BRK_CAUSE = 3;

  typedef struct packed {
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       mie;
    logic       sie;
  } status_t;
endpackage

// File: rtl/trap_cfg_regs.sv
module trap_cfg_regs
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] EDELEG_MASK = '0,
  parameter logic [XLEN-1:0] IDELEG_MASK = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      sel_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] mvec_o,
  output logic [XLEN-1:0] svec_o,
  output logic [XLEN-1:0] edeleg_o,
  output logic [XLEN-1:0] ideleg_o
);
  localparam int unsigned NREG = 4;
  localparam logic [XLEN-1:0] MVEC_MASK = ~(XLEN'(2));
  localparam logic [XLEN-1:0] SVEC_MASK = ~(XLEN'(3));

  logic [NREG-1:0][XLEN-1:0] wmask;
  logic [NREG-1:0][XLEN-1:0] regs_q;

  assign wmask[0] = MVEC_MASK;
  assign wmask[1] = SVEC_MASK;
  assign wmask[2] = EDELEG_MASK;
  assign wmask[3] = IDELEG_MASK;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && sel_i == 3'(g)) regs_q[g] <= wdata_i & wmask[g];
    end
  end

  assign mvec_o   = regs_q[0];
  assign svec_o   = regs_q[1];
  assign edeleg_o = regs_q[2];
  assign ideleg_o = regs_q[3];
endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY_PC = '0,
  parameter logic [XLEN-1:0] DBG_EXC_PC = '0
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [1:0]      priv_i,
  input  logic            dbg_i,
  input  logic [XLEN-1:0] edeleg_i,
  input  logic [XLEN-1:0] ideleg_i,
  input  logic [XLEN-1:0] mvec_i,
  input  logic [XLEN-1:0] svec_i,
  output logic            to_s_o,
  output logic [XLEN-1:0] target_pc_o
);
  localparam int unsigned IW = $clog2(XLEN);
  localparam logic [XLEN-2:0] XLEN_V = (XLEN-1)'(XLEN);

  logic            is_int;
  logic [XLEN-2:0] idx;
  logic            idx_ok;
  logic [XLEN-1:0] deleg;
  logic            deleg_bit;
  logic            low_priv;
  logic            is_brk;
  logic [XLEN-1:0] vec_off;
  logic [XLEN-1:0] m_pc;

  assign is_int    = cause_i[XLEN-1];
  assign idx       = cause_i[XLEN-2:0];
  assign idx_ok    = idx < XLEN_V;
  assign deleg     = is_int ? ideleg_i : edeleg_i;
  assign deleg_bit = idx_ok && deleg[idx[IW-1:0]];
  assign low_priv  = (priv_i == PRIV_U) || (priv_i == PRIV_S);
  assign to_s_o    = low_priv && deleg_bit;
  assign is_brk    = !is_int && (idx == (XLEN-1)'(BRK_CAUSE));
  assign vec_off   = (mvec_i[0] && is_int) ? {cause_i[XLEN-3:0], 2'b00} : '0;
  assign m_pc      = {mvec_i[XLEN-1:1], 1'b0} + vec_off;

  always_comb begin
    if (dbg_i)       target_pc_o = is_brk ? DBG_ENTRY_PC : DBG_EXC_PC;
    else if (to_s_o) target_pc_o = svec_i;
    else             target_pc_o = m_pc;
  end
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 take_i,
  input  logic                 dbg_i,
  input  logic                 to_s_i,
  input  logic [XLEN-1:0]      target_pc_i,
  input  logic [XLEN-1:0]      cause_i,
  input  logic [XLEN-1:0]      epc_i,
  input  logic [XLEN-1:0]      bad_i,
  input  logic                 bad_vld_i,
  input  logic                 cfg_we_i,
  input  logic [2:0]           cfg_sel_i,
  input  logic [XLEN-1:0]      cfg_wdata_i,
  output logic [XLEN-1:0]      pc_o,
  output logic [1:0]           priv_o,
  output status_t              status_o,
  output logic [1:0][XLEN-1:0] epc_o,
  output logic [1:0][XLEN-1:0] cause_o,
  output logic [1:0][XLEN-1:0] bad_o
);
  localparam int unsigned NLVL = 2; // 0 supervisor, 1 machine

  logic    upd;
  logic    to_s;
  status_t st_q, st_d;
  logic [1:0] priv_q, priv_d;
  logic [XLEN-1:0] pc_q;

  assign upd  = take_i && !dbg_i;
  assign to_s = to_s_i;

  always_comb begin
    st_d   = st_q;
    priv_d = priv_q;
    if (upd) begin
      if (to_s) begin
        st_d.spie = st_q.sie;
        st_d.spp  = priv_q[0];
        st_d.sie  = 1'b0;
        priv_d    = PRIV_S;
      end else begin
        st_d.mpie = st_q.mie;
        st_d.mpp  = priv_q;
        st_d.mie  = 1'b0;
        priv_d    = PRIV_M;
      end
    end else if (cfg_we_i && cfg_sel_i == SEL_STATUS) begin
      st_d.sie  = cfg_wdata_i[POS_SIE];
      st_d.mie  = cfg_wdata_i[POS_MIE];
      st_d.spie = cfg_wdata_i[POS_SPIE];
      st_d.mpie = cfg_wdata_i[POS_MPIE];
      st_d.spp  = cfg_wdata_i[POS_SPP];
      st_d.mpp  = cfg_wdata_i[POS_MPP+1:POS_MPP];
    end else if (cfg_we_i && cfg_sel_i == SEL_PRIV && cfg_wdata_i[1:0] != PRIV_RSV) begin
      priv_d = cfg_wdata_i[1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      priv_q <= PRIV_M;
      pc_q   <= RESET_PC;
    end else begin
      st_q   <= st_d;
      priv_q <= priv_d;
      if (take_i) pc_q <= target_pc_i;
    end
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    logic hit;
    logic [XLEN-1:0] epc_q, cause_q, bad_q;
    assign hit = upd && (to_s == (g == 0));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        epc_q   <= '0;
        cause_q <= '0;
        bad_q   <= '0;
      end else if (hit) begin
        epc_q   <= epc_i;
        cause_q <= cause_i;
        if (bad_vld_i) bad_q <= bad_i;
      end
    end
    assign epc_o[g]   = epc_q;
    assign cause_o[g] = cause_q;
    assign bad_o[g]   = bad_q;
  end

  assign pc_o     = pc_q;
  assign priv_o   = priv_q;
  assign status_o = st_q;
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h0000_1000),
  parameter logic [XLEN-1:0] DBG_ENTRY_PC = XLEN'(32'h0000_0800),
  parameter logic [XLEN-1:0] DBG_EXC_PC = XLEN'(32'h0000_0808),
  parameter logic [XLEN-1:0] EDELEG_MASK = XLEN'(32'h0000_B109),
  parameter logic [XLEN-1:0] IDELEG_MASK = XLEN'(32'h0000_0222)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] badaddr_i,
  input  logic            badaddr_vld_i,
  input  logic            dbg_mode_i,
  input  logic            cfg_we_i,
  input  logic [2:0]      cfg_sel_i,
  input  logic [XLEN-1:0] cfg_wdata_i,
  output logic [XLEN-1:0] pc_o,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] stvec_o,
  output logic [XLEN-1:0] medeleg_o,
  output logic [XLEN-1:0] mideleg_o,
  output logic            sie_o,
  output logic            spie_o,
  output logic            spp_o,
  output logic            mie_o,
  output logic            mpie_o,
  output logic [1:0]      mpp_o,
  output logic [XLEN-1:0] sepc_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] sbadaddr_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mbadaddr_o
);
  logic                 cfg_we;
  logic                 to_s;
  logic [XLEN-1:0]      target_pc;
  status_t              st;
  logic [1:0][XLEN-1:0] epc_l, cause_l, bad_l;

  // a trap in the same cycle wins over a configuration write
  assign cfg_we = cfg_we_i && !take_i;

  trap_cfg_regs #(
    .XLEN(XLEN), .EDELEG_MASK(EDELEG_MASK), .IDELEG_MASK(IDELEG_MASK)
  ) cfg_i (
    .clk_i, .rst_ni,
    .we_i(cfg_we), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .mvec_o(mtvec_o), .svec_o(stvec_o), .edeleg_o(medeleg_o), .ideleg_o(mideleg_o)
  );

  trap_router #(
    .XLEN(XLEN), .DBG_ENTRY_PC(DBG_ENTRY_PC), .DBG_EXC_PC(DBG_EXC_PC)
  ) route_i (
    .cause_i, .priv_i(priv_o), .dbg_i(dbg_mode_i),
    .edeleg_i(medeleg_o), .ideleg_i(mideleg_o), .mvec_i(mtvec_o), .svec_i(stvec_o),
    .to_s_o(to_s), .target_pc_o(target_pc)
  );

  trap_state_regs #(
    .XLEN(XLEN), .RESET_PC(RESET_PC)
  ) state_i (
    .clk_i, .rst_ni,
    .take_i, .dbg_i(dbg_mode_i), .to_s_i(to_s), .target_pc_i(target_pc),
    .cause_i, .epc_i, .bad_i(badaddr_i), .bad_vld_i(badaddr_vld_i),
    .cfg_we_i(cfg_we), .cfg_sel_i, .cfg_wdata_i,
    .pc_o, .priv_o, .status_o(st),
    .epc_o(epc_l), .cause_o(cause_l), .bad_o(bad_l)
  );

  assign sie_o      = st.sie;
  assign spie_o     = st.spie;
  assign spp_o      = st.spp;
  assign mie_o      = st.mie;
  assign mpie_o     = st.mpie;
  assign mpp_o      = st.mpp;
  assign sepc_o     = epc_l[0];
  assign scause_o   = cause_l[0];
  assign sbadaddr_o = bad_l[0];
  assign mepc_o     = epc_l[1];
  assign mcause_o   = cause_l[1];
  assign mbadaddr_o = bad_l[1];
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] EDELEG_MASK = '0,
  parameter logic [XLEN-1:0] IDELEG_MASK = '0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            take_i,
  input logic            dbg_mode_i,
  input logic            cfg_we_i,
  input logic [1:0]      priv_o,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] mtvec_o,
  input logic [XLEN-1:0] medeleg_o,
  input logic [XLEN-1:0] mideleg_o,
  input logic            sie_o,
  input logic            spie_o,
  input logic            mie_o,
  input logic            mpie_o,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] sepc_o
);
  assert_mach_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !dbg_mode_i && priv_o == 2'd3) |=> (priv_o == 2'd3));

  assert_s_stack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !dbg_mode_i) |=> (priv_o != 2'd1 || (!sie_o && spie_o == $past(sie_o))));

  assert_m_stack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !dbg_mode_i) |=> (priv_o != 2'd3 || (!mie_o && mpie_o == $past(mie_o))));

  assert_mvec_bit1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mtvec_o[1] == 1'b0);

  assert_dbg_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && dbg_mode_i) |=> ($stable(priv_o) && $stable(mepc_o) && $stable(sepc_o)
                                && $stable(mie_o) && $stable(sie_o)));

  assert_deleg_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((medeleg_o & ~EDELEG_MASK) == '0) && ((mideleg_o & ~IDELEG_MASK) == '0));

  assert_idle_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !cfg_we_i) |=> ($stable(priv_o) && $stable(pc_o) && $stable(mtvec_o)));
endmodule

bind trap_entry_unit trap_entry_chk #(
  .XLEN(XLEN), .EDELEG_MASK(EDELEG_MASK), .IDELEG_MASK(IDELEG_MASK)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take_i), .dbg_mode_i(dbg_mode_i),
  .cfg_we_i(cfg_we_i), .priv_o(priv_o), .pc_o(pc_o), .mtvec_o(mtvec_o),
  .medeleg_o(medeleg_o), .mideleg_o(mideleg_o), .sie_o(sie_o), .spie_o(spie_o),
  .mie_o(mie_o), .mpie_o(mpie_o), .mepc_o(mepc_o), .sepc_o(sepc_o)
);

// File: tb/trap_entry_unit_tb_top.sv
`timescale 1ns/1ps
module trap_entry_unit_tb_top;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic        take = 0, bvld = 0, dbg = 0, cwe = 0;
  logic [31:0] cause = 0, epc = 0, bad = 0, cwd = 0;
  logic [2:0]  csel = 0;

  logic [31:0] pc, mtvec, stvec, medeleg, mideleg, sepc, scause, sbad, mepc, mcause, mbad;
  logic [1:0]  priv, mpp;
  logic        sie, spie, spp, mie, mpie;

  trap_entry_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .take_i(take), .cause_i(cause), .epc_i(epc),
    .badaddr_i(bad), .badaddr_vld_i(bvld), .dbg_mode_i(dbg), .cfg_we_i(cwe),
    .cfg_sel_i(csel), .cfg_wdata_i(cwd), .pc_o(pc), .priv_o(priv), .mtvec_o(mtvec),
    .stvec_o(stvec), .medeleg_o(medeleg), .mideleg_o(mideleg), .sie_o(sie),
    .spie_o(spie), .spp_o(spp), .mie_o(mie), .mpie_o(mpie), .mpp_o(mpp),
    .sepc_o(sepc), .scause_o(scause), .sbadaddr_o(sbad), .mepc_o(mepc),
    .mcause_o(mcause), .mbadaddr_o(mbad)
  );

  int errors = 0, checks = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] r_pc, r_mvec, r_svec, r_ed, r_id, r_sepc, r_sc, r_sb, r_mepc, r_mc, r_mb;
  logic [1:0]  r_priv, r_mpp;
  logic        r_sie, r_spie, r_spp, r_mie, r_mpie;

  task automatic model_reset();
    r_pc = 32'h1000; r_priv = 2'd3;
    r_mvec = 0; r_svec = 0; r_ed = 0; r_id = 0;
    r_sepc = 0; r_sc = 0; r_sb = 0; r_mepc = 0; r_mc = 0; r_mb = 0;
    r_sie = 0; r_spie = 0; r_spp = 0; r_mie = 0; r_mpie = 0; r_mpp = 0;
  endtask

  task automatic model_step();
    int idx;
    bit irq, dlg;
    if (take) begin
      irq = cause[31];
      idx = int'(cause & 32'h7fff_ffff);
      if (dbg) begin
        r_pc = (!irq && idx == 3) ? 32'h800 : 32'h808;
      end else begin
        if (idx < 32) dlg = irq ? r_id[idx] : r_ed[idx];
        else dlg = 0;
        if (r_priv <= 2'd1 && dlg) begin
          r_spie = r_sie; r_spp = r_priv[0]; r_sie = 0;
          r_sepc = epc; r_sc = cause;
          if (bvld) r_sb = bad;
          r_pc = r_svec; r_priv = 2'd1;
        end else begin
          r_mpie = r_mie; r_mpp = r_priv; r_mie = 0;
          r_mepc = epc; r_mc = cause;
          if (bvld) r_mb = bad;
          r_pc = (r_mvec & ~32'd1) + ((r_mvec[0] && irq) ? 32'(idx * 4) : 32'd0);
          r_priv = 2'd3;
        end
      end
    end else if (cwe) begin
      case (csel)
        3'd0: r_mvec = cwd & ~32'd2;
        3'd1: r_svec = cwd & ~32'd3;
        3'd2: r_ed = cwd & 32'h0000_B109;
        3'd3: r_id = cwd & 32'h0000_0222;
        3'd4: begin
          r_sie = cwd[1]; r_mie = cwd[3]; r_spie = cwd[5]; r_mpie = cwd[7];
          r_spp = cwd[8]; r_mpp = cwd[12:11];
        end
        3'd5: if (cwd[1:0] != 2'd2) r_priv = cwd[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "pc", pc, r_pc);
    chk(cur_req, "priv", {30'd0, priv}, {30'd0, r_priv});
    chk(cur_req, "mtvec", mtvec, r_mvec);
    chk(cur_req, "stvec", stvec, r_svec);
    chk(cur_req, "medeleg", medeleg, r_ed);
    chk(cur_req, "mideleg", mideleg, r_id);
    chk(cur_req, "status", {25'd0, mpp, spp, mpie, spie, mie, sie},
        {25'd0, r_mpp, r_spp, r_mpie, r_spie, r_mie, r_sie});
    chk(cur_req, "sepc", sepc, r_sepc);
    chk(cur_req, "scause", scause, r_sc);
    chk(cur_req, "sbad", sbad, r_sb);
    chk(cur_req, "mepc", mepc, r_mepc);
    chk(cur_req, "mcause", mcause, r_mc);
    chk(cur_req, "mbad", mbad, r_mb);
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst_n) model_step();
    #2;
    if (rst_n) compare_all();
  end

  task automatic idle();
    @(negedge clk);
    take = 0; cwe = 0; bvld = 0;
  endtask

  task automatic cfg(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    take = 0; cwe = 1; csel = s; cwd = d;
    @(negedge clk);
    cwe = 0;
  endtask

  task automatic trap(logic [31:0] c, logic [31:0] e, logic v, logic [31:0] b);
    @(negedge clk);
    cwe = 0; take = 1; cause = c; epc = e; bvld = v; bad = b;
    @(negedge clk);
    take = 0; bvld = 0;
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20;
    cur_req = "R1";
    chk("R1", "reset pc", pc, 32'h1000);
    chk("R1", "reset priv", {30'd0, priv}, 32'd3);
    chk("R1", "reset mepc", mepc, 32'd0);
    @(negedge clk); rst_n = 1;
    idle(); idle();

    cur_req = "R7";
    cfg(3'd0, 32'h0000_2003);
    chk("R7", "mtvec bit1 cleared", mtvec, 32'h0000_2001);
    cfg(3'd1, 32'h0000_3007);
    chk("R7", "stvec low bits cleared", stvec, 32'h0000_3004);

    cur_req = "R12";
    cfg(3'd4, 32'h0000_0008); // mie=1
    chk("R12", "status mie", {31'd0, mie}, 32'd1);

    cur_req = "R6";
    trap(32'h0000_0002, 32'h100, 1, 32'hdead_0000);
    chk("R6", "exception not vectored", pc, 32'h2000);
    chk("R8", "mbad loaded when valid", mbad, 32'hdead_0000);

    cur_req = "R5";
    cfg(3'd4, 32'h0000_0008);
    trap(32'h8000_0007, 32'h104, 0, 32'h1111);
    chk("R6", "vectored irq pc", pc, 32'h2000 + 28);
    chk("R5", "mpie took mie", {31'd0, mpie}, 32'd1);
    chk("R5", "mie cleared", {31'd0, mie}, 32'd0);
    chk("R8", "mbad kept when invalid", mbad, 32'hdead_0000);

    cur_req = "R10";
    cfg(3'd2, 32'hFFFF_FFFF);
    chk("R10", "edeleg mask", medeleg, 32'h0000_B109);
    cfg(3'd3, 32'hFFFF_FFFF);
    chk("R10", "ideleg mask", mideleg, 32'h0000_0222);

    cur_req = "R3";
    trap(32'h0000_0008, 32'h108, 0, 0);
    chk("R3", "machine stays machine", {30'd0, priv}, 32'd3);

    cur_req = "R12";
    cfg(3'd5, 32'h0000_0002);
    chk("R12", "reserved priv ignored", {30'd0, priv}, 32'd3);
    cfg(3'd5, 32'h0000_0000);
    cfg(3'd4, 32'h0000_0002); // sie=1

    cur_req = "R4";
    trap(32'h0000_0008, 32'h200, 0, 32'h5555);
    chk("R4", "user ecall to supervisor", {30'd0, priv}, 32'd1);
    chk("R4", "pc is stvec", pc, 32'h3004);
    chk("R4", "spie took sie", {31'd0, spie}, 32'd1);
    chk("R8", "sbad kept when invalid", sbad, 32'd0);

    cur_req = "R2";
    trap(32'h8000_0005, 32'h204, 1, 32'h7777);
    chk("R2", "delegated irq to supervisor", {30'd0, priv}, 32'd1);
    chk("R4", "spp records supervisor", {31'd0, spp}, 32'd1);
    trap(32'h0000_0002, 32'h208, 0, 0);
    chk("R2", "undelegated exc to machine", {30'd0, priv}, 32'd3);
    chk("R5", "mpp records supervisor", {30'd0, mpp}, 32'd1);

    cfg(3'd5, 32'h0000_0000);
    trap(32'h8000_0028, 32'h20c, 0, 0);
    chk("R2", "index beyond XLEN to machine", {30'd0, priv}, 32'd3);
    chk("R6", "vector offset for index 40", pc, 32'h2000 + 160);
    cfg(3'd5, 32'h0000_0001);
    trap(32'h8000_0001, 32'h210, 0, 0);
    trap(32'h8000_0003, 32'h214, 0, 0);
    cfg(3'd0, 32'h0000_4000);
    cfg(3'd5, 32'h0000_0001);
    trap(32'h8000_0003, 32'h218, 0, 0);
    chk("R6", "direct mode irq pc", pc, 32'h4000);

    cur_req = "R9";
    dbg = 1;
    trap(32'h0000_0003, 32'h300, 1, 32'h9999);
    chk("R9", "debug breakpoint entry", pc, 32'h800);
    trap(32'h0000_0002, 32'h304, 1, 32'h9999);
    chk("R9", "debug other exception", pc, 32'h808);
    chk("R9", "mepc untouched in debug", mepc, 32'h218);
    trap(32'h8000_0003, 32'h308, 0, 0);
    chk("R9", "debug irq cause 3 not breakpoint", pc, 32'h808);
    dbg = 0;

    cur_req = "R12";
    @(negedge clk);
    take = 1; cause = 32'h0000_0002; epc = 32'h400; cwe = 1; csel = 3'd0; cwd = 32'h0000_8000;
    @(negedge clk);
    take = 0; cwe = 0;
    chk("R12", "cfg write dropped under trap", mtvec, 32'h4000);

    cur_req = "R11";
    repeat (4) idle();
    chk("R11", "idle keeps pc", pc, 32'h4000);

    repeat (2) idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule